// File: doc/BRIEF.md
# I2C Transfer Sequencer

This block sits between a host command path and a byte-level I2C bus engine. The host opens a transfer with a command. The command carries a begin flag, an end flag, a direction flag, a 7-bit target address and a byte length. The sequencer issues a start or a repeated start and then sends the address byte. It records in a readable status whether the target answered. If the target acknowledged, the length becomes the remaining byte budget.

The host then moves data in chunks of any size. A write chunk pulls bytes from the host one at a time and sends them on the bus. A read chunk fetches bytes from the bus and hands each one back to the host. The sequencer counts the budget down and cuts off any chunk that asks for more than is left. It sends a stop only when the transfer was opened with the end flag and the budget has run out. This lets one bus transaction span several commands and many chunks. If the address was refused, chunks make no bus traffic: reads return zero bytes and writes are dropped.

The engine is driven by a held request, an operation code and a write byte. It answers with a one-cycle acknowledge pulse that carries the bus acknowledge bit and any byte that was read. The sequencer accepts a command or a chunk only while it is not busy. If both arrive in the same cycle, the command wins.

Top module: `i2cseq_top`

## Requirements
- R1: The address byte is sent as an engine write (op code 3) directly after the start condition. Its value is the 7-bit address in bits 7:1 and the read flag in bit 0.
- R2: A command with the begin flag opens with op code 0 (start). A command without it opens with op code 1 (repeated start).
- R3: When the address byte is not acknowledged, status becomes 2, a stop (op code 2) follows at once, and the remaining budget becomes zero.
- R4: When the address byte is acknowledged, status becomes 1 and the budget is loaded from the length. No stop follows unless R5 applies.
- R5: An acknowledged command with the end flag and a length of zero is followed by a stop right after the address byte.
- R6: Status reads 0 after reset and only ever holds 0, 1 or 2. It changes only while the block is busy.
- R7: With status 1, a chunk handles the smaller of its requested size and the remaining budget, and reports that number on done_count.
- R8: A read chunk issues one read (op code 4) per byte and presents each byte on rd_data with rd_valid. The read that takes the budget to zero carries the not-acknowledge request, and no other read does.
- R9: After a chunk with status 1, a stop is issued when the opening command had the end flag and the budget is zero. Otherwise no stop is issued.
- R10: With status other than 1, a chunk makes no engine request and reports its full requested size. A read chunk yields that many zero bytes. A write chunk takes no byte from the host.
- R11: A data byte that is not acknowledged does not end the chunk, and wr_err becomes 1. wr_err returns to 0 when the next command is accepted.
- R12: done is a single-cycle pulse after all bus work of a command or chunk, including any stop. busy is low, with no engine request, in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken while not busy |
| cmd_begin | input | 1 | Open with a start instead of a repeated start |
| cmd_end | input | 1 | Allow a stop once the budget is used up |
| cmd_read | input | 1 | Direction bit placed in the address byte |
| cmd_addr | input | 7 | Target address |
| cmd_len | input | LEN_W | Byte budget of the transfer |
| chunk_valid | input | 1 | Data chunk strobe, taken while not busy |
| chunk_write | input | 1 | 1 for a write chunk, 0 for a read chunk |
| chunk_len | input | LEN_W | Requested chunk size in bytes |
| wr_data | input | 8 | Next host byte to send, held until wr_take |
| wr_take | output | 1 | Host byte consumed |
| rd_valid | output | 1 | Read byte present on rd_data |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Command or chunk finished |
| done_count | output | LEN_W | Bytes handled by the finished chunk |
| busy | output | 1 | Sequencer is working |
| status | output | 2 | 0 idle, 1 address acknowledged, 2 address refused |
| wr_err | output | 1 | A written data byte was refused |
| eng_req | output | 1 | Engine request, held until eng_ack |
| eng_op | output | 3 | 0 start, 1 repeated start, 2 stop, 3 write, 4 read |
| eng_wdata | output | 8 | Byte for a write operation |
| eng_nack_last | output | 1 | Answer this read with not-acknowledge |
| eng_ack | input | 1 | Engine finished the requested operation |
| eng_rx_ack | input | 1 | Bus acknowledge seen on a write |
| eng_rdata | input | 8 | Byte returned by a read |

## Verification
A wrong budget count shows up within one chunk. done_count is off, the engine op count is off, a stop appears or goes missing, or the not-acknowledge flag lands on the wrong read. A corrupted status or saved end flag shows on the status port at once. It also changes whether the next chunk makes bus traffic or returns zeros. A stuck error flag shows on wr_err when the next command is accepted.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [2:0] {
      OP_START   = 3'd0,
      OP_RESTART = 3'd1,
      OP_STOP    = 3'd2,
      OP_WRITE   = 3'd3,
      OP_READ    = 3'd4
   } bus_op_e;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_ACK  = 2'd1,
      XS_NAK  = 2'd2
   } xfer_stat_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_COND,
      SQ_ADDR,
      SQ_DATA,
      SQ_FILL,
      SQ_STOP,
      SQ_DONE
   } seq_state_e;

   localparam int ADDR_BITS = 7;
   localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cseq_budget.sv
module i2cseq_budget #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   input  logic [LEN_W-1:0] req_len,
   output logic [LEN_W-1:0] grant,
   output logic             rem_zero,
   output logic             rem_last
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] rem_q;

   if (LEN_W < 2) begin : g_bad_width
      $error("i2cseq_budget: LEN_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= load_val;
      end else if (dec && (rem_q != '0)) begin
         rem_q <= rem_q - ONE;
      end
   end

   assign grant    = (req_len > rem_q) ? rem_q : req_len;
   assign rem_zero = (rem_q == '0);
   assign rem_last = (rem_q == ONE);

endmodule

// File: rtl/i2cseq_status.sv
module i2cseq_status
   import i2cseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_ack,
   input  logic       set_nak,
   input  logic       end_in,
   input  logic       cmd_take,
   input  logic       err_evt,
   output logic [1:0] status,
   output logic       is_ack,
   output logic       saved_end,
   output logic       wr_err
);
   xfer_stat_e stat_q;
   logic       end_q;
   logic       err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= XS_IDLE;
         end_q  <= 1'b0;
      end else if (set_ack) begin
         stat_q <= XS_ACK;
         end_q  <= end_in;
      end else if (set_nak) begin
         stat_q <= XS_NAK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (cmd_take) begin
         err_q <= 1'b0;
      end else if (err_evt) begin
         err_q <= 1'b1;
      end
   end

   assign status    = stat_q;
   assign is_ack    = (stat_q == XS_ACK);
   assign saved_end = end_q;
   assign wr_err    = err_q;

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_begin,
   input  logic                 cmd_end,
   input  logic                 cmd_read,
   input  logic [ADDR_BITS-1:0] cmd_addr,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic                 chunk_valid,
   input  logic                 chunk_write,
   input  logic [LEN_W-1:0]     chunk_len,
   input  logic [BYTE_BITS-1:0] wr_data,
   input  logic                 eng_ack,
   input  logic                 eng_rx_ack,
   input  logic [BYTE_BITS-1:0] eng_rdata,
   input  logic                 stat_is_ack,
   input  logic                 saved_end,
   input  logic [LEN_W-1:0]     grant,
   input  logic                 rem_zero,
   input  logic                 rem_last,
   output logic                 eng_req,
   output logic [2:0]           eng_op,
   output logic [BYTE_BITS-1:0] eng_wdata,
   output logic                 eng_nack_last,
   output logic                 wr_take,
   output logic                 rd_valid,
   output logic [BYTE_BITS-1:0] rd_data,
   output logic                 done,
   output logic [LEN_W-1:0]     done_count,
   output logic                 busy,
   output logic                 load_rem,
   output logic [LEN_W-1:0]     rem_val,
   output logic                 dec_rem,
   output logic                 set_ack,
   output logic                 set_nak,
   output logic                 end_out,
   output logic                 cmd_take,
   output logic                 err_evt
);
   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   seq_state_e           state_q, state_d;
   logic                 begin_q, end_q, read_q, dir_wr_q;
   logic [ADDR_BITS-1:0] addr_q;
   logic [LEN_W-1:0]     len_q, target_q, cnt_q, dcount_q;
   bus_op_e              op_c;
   logic                 req_c, nack_c, cnt_inc, fin, fill_rd, chunk_take;
   logic [LEN_W-1:0]     fin_val;
   logic                 data_hit;

   assign data_hit = (cnt_q == target_q);

   always_comb begin
      state_d    = state_q;
      req_c      = 1'b0;
      op_c       = OP_WRITE;
      eng_wdata  = '0;
      nack_c     = 1'b0;
      load_rem   = 1'b0;
      rem_val    = '0;
      dec_rem    = 1'b0;
      set_ack    = 1'b0;
      set_nak    = 1'b0;
      cmd_take   = 1'b0;
      chunk_take = 1'b0;
      err_evt    = 1'b0;
      cnt_inc    = 1'b0;
      fin        = 1'b0;
      fin_val    = '0;
      fill_rd    = 1'b0;
      unique case (state_q)
         SQ_IDLE: begin
            if (cmd_valid) begin
               cmd_take = 1'b1;
               state_d  = SQ_COND;
            end else if (chunk_valid) begin
               chunk_take = 1'b1;
               state_d    = stat_is_ack ? SQ_DATA : SQ_FILL;
            end
         end
         SQ_COND: begin
            req_c = 1'b1;
            op_c  = begin_q ? OP_START : OP_RESTART;
            if (eng_ack) state_d = SQ_ADDR;
         end
         SQ_ADDR: begin
            req_c     = 1'b1;
            op_c      = OP_WRITE;
            eng_wdata = {addr_q, read_q};
            if (eng_ack) begin
               fin      = 1'b1;
               load_rem = 1'b1;
               if (eng_rx_ack) begin
                  set_ack = 1'b1;
                  rem_val = len_q;
                  state_d = (end_q && (len_q == '0)) ? SQ_STOP : SQ_DONE;
               end else begin
                  set_nak = 1'b1;
                  state_d = SQ_STOP;
               end
            end
         end
         SQ_DATA: begin
            op_c      = dir_wr_q ? OP_WRITE : OP_READ;
            eng_wdata = wr_data;
            if (data_hit) begin
               fin     = 1'b1;
               fin_val = cnt_q;
               state_d = (saved_end && rem_zero) ? SQ_STOP : SQ_DONE;
            end else begin
               req_c  = 1'b1;
               nack_c = !dir_wr_q && rem_last;
               if (eng_ack) begin
                  dec_rem = 1'b1;
                  cnt_inc = 1'b1;
                  err_evt = dir_wr_q && !eng_rx_ack;
               end
            end
         end
         SQ_FILL: begin
            if (dir_wr_q || data_hit) begin
               fin     = 1'b1;
               fin_val = target_q;
               state_d = SQ_DONE;
            end else begin
               fill_rd = 1'b1;
               cnt_inc = 1'b1;
            end
         end
         SQ_STOP: begin
            req_c = 1'b1;
            op_c  = OP_STOP;
            if (eng_ack) state_d = SQ_DONE;
         end
         SQ_DONE: state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         begin_q  <= 1'b0;
         end_q    <= 1'b0;
         read_q   <= 1'b0;
         addr_q   <= '0;
         len_q    <= '0;
         dir_wr_q <= 1'b0;
         target_q <= '0;
         cnt_q    <= '0;
         dcount_q <= '0;
      end else begin
         state_q <= state_d;
         if (cmd_take) begin
            begin_q <= cmd_begin;
            end_q   <= cmd_end;
            read_q  <= cmd_read;
            addr_q  <= cmd_addr;
            len_q   <= cmd_len;
         end
         if (chunk_take) begin
            dir_wr_q <= chunk_write;
            target_q <= stat_is_ack ? grant : chunk_len;
            cnt_q    <= '0;
         end else if (cnt_inc) begin
            cnt_q <= cnt_q + ONE;
         end
         if (fin) dcount_q <= fin_val;
      end
   end

   assign eng_req       = req_c;
   assign eng_op        = op_c;
   assign eng_nack_last = nack_c;
   assign end_out       = end_q;
   assign wr_take       = (state_q == SQ_DATA) && dir_wr_q && eng_ack;
   assign rd_valid      = ((state_q == SQ_DATA) && !dir_wr_q && eng_ack) || fill_rd;
   assign rd_data       = fill_rd ? '0 : eng_rdata;
   assign done          = (state_q == SQ_DONE);
   assign done_count    = dcount_q;
   assign busy          = (state_q != SQ_IDLE);

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_begin,
   input  logic             cmd_end,
   input  logic             cmd_read,
   input  logic [6:0]       cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             chunk_valid,
   input  logic             chunk_write,
   input  logic [LEN_W-1:0] chunk_len,
   input  logic [7:0]       wr_data,
   output logic             wr_take,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [LEN_W-1:0] done_count,
   output logic             busy,
   output logic [1:0]       status,
   output logic             wr_err,
   output logic             eng_req,
   output logic [2:0]       eng_op,
   output logic [7:0]       eng_wdata,
   output logic             eng_nack_last,
   input  logic             eng_ack,
   input  logic             eng_rx_ack,
   input  logic [7:0]       eng_rdata
);
   if (LEN_W < 2 || LEN_W > 16) begin : g_bad_len
      $error("i2cseq_top: LEN_W must lie in 2..16");
   end

   logic             stat_is_ack, saved_end, rem_zero, rem_last;
   logic [LEN_W-1:0] grant, rem_val;
   logic             load_rem, dec_rem, set_ack, set_nak, end_out, cmd_take, err_evt;

   i2cseq_ctrl #(.LEN_W(LEN_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_begin(cmd_begin), .cmd_end(cmd_end),
      .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .chunk_valid(chunk_valid), .chunk_write(chunk_write), .chunk_len(chunk_len),
      .wr_data(wr_data),
      .eng_ack(eng_ack), .eng_rx_ack(eng_rx_ack), .eng_rdata(eng_rdata),
      .stat_is_ack(stat_is_ack), .saved_end(saved_end),
      .grant(grant), .rem_zero(rem_zero), .rem_last(rem_last),
      .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata),
      .eng_nack_last(eng_nack_last),
      .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .done_count(done_count), .busy(busy),
      .load_rem(load_rem), .rem_val(rem_val), .dec_rem(dec_rem),
      .set_ack(set_ack), .set_nak(set_nak), .end_out(end_out),
      .cmd_take(cmd_take), .err_evt(err_evt)
   );

   i2cseq_budget #(.LEN_W(LEN_W)) budget_i (
      .clk(clk), .rst_n(rst_n),
      .load(load_rem), .load_val(rem_val), .dec(dec_rem),
      .req_len(chunk_len), .grant(grant),
      .rem_zero(rem_zero), .rem_last(rem_last)
   );

   i2cseq_status status_i (
      .clk(clk), .rst_n(rst_n),
      .set_ack(set_ack), .set_nak(set_nak), .end_in(end_out),
      .cmd_take(cmd_take), .err_evt(err_evt),
      .status(status), .is_ack(stat_is_ack),
      .saved_end(saved_end), .wr_err(wr_err)
   );

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       eng_req,
   input logic       eng_ack,
   input logic [2:0] eng_op,
   input logic       eng_nack_last,
   input logic       wr_take,
   input logic       rd_valid,
   input logic [7:0] rd_data,
   input logic       done,
   input logic       busy,
   input logic [1:0] status
);
   a_r6_status_code: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'd3);

   a_r6_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(status));

   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !eng_req);

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op)));

   a_r10_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && status != 2'd1) |-> (rd_data == 8'h00));

   a_r11_take_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> (eng_ack && eng_op == 3'd3));

   a_r8_nack_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      eng_nack_last |-> (eng_req && eng_op == 3'd4));

endmodule

bind i2cseq_top i2cseq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_ack(eng_ack),
   .eng_op(eng_op), .eng_nack_last(eng_nack_last), .wr_take(wr_take),
   .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .busy(busy),
   .status(status)
);

// File: tb/i2cseq_top_tb_top.sv
`timescale 1ns/1ps
module i2cseq_top_tb_top;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 0, cmd_begin = 0, cmd_end = 0, cmd_read = 0;
   logic [6:0]    cmd_addr = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          chunk_valid = 0, chunk_write = 0;
   logic [LW-1:0] chunk_len = '0;
   logic [7:0]    wr_data;
   logic          wr_take, rd_valid, done, busy, wr_err;
   logic [7:0]    rd_data, eng_wdata;
   logic [LW-1:0] done_count;
   logic [1:0]    status;
   logic          eng_req, eng_nack_last;
   logic [2:0]    eng_op;
   logic          eng_ack = 0, eng_rx_ack = 0;
   logic [7:0]    eng_rdata = '0;

   int nvec = 0, nfail = 0;
   int nlog = 0, nrd = 0, widx = 0, rdn = 0;
   logic [2:0] lg_op  [0:1023];
   logic [7:0] lg_dat [0:1023];
   logic       lg_nk  [0:1023];
   logic [7:0] rq     [0:1023];
   logic [1:0] ecnt = 0;
   logic [2:0] prev_op = 3'd2;

   int m_rem = 0, m_stat = 0, erdn = 0, ewi = 0;
   bit m_end = 0, m_err = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] wbyte(int i);
      return (i % 5 == 3) ? 8'hEE : 8'(8'h30 + i);
   endfunction
   assign wr_data = wbyte(widx);

   i2cseq_top #(.LEN_W(LW)) dut_i (.*);

   // bus engine model
   always @(negedge clk) begin
      eng_ack <= 1'b0;
      if (!rst_n) ecnt <= 0;
      else if (eng_req && !eng_ack) begin
         if (ecnt == 2'd2) begin
            ecnt <= 0;
            eng_ack <= 1'b1;
            lg_op[nlog]  <= eng_op;
            lg_dat[nlog] <= eng_wdata;
            lg_nk[nlog]  <= eng_nack_last;
            nlog <= nlog + 1;
            if (eng_op == 3'd3)
               eng_rx_ack <= (prev_op <= 3'd1) ? (eng_wdata[7:1] < 7'h40) : (eng_wdata != 8'hEE);
            if (eng_op == 3'd4) begin
               eng_rdata <= 8'(8'hA0 + rdn);
               rdn <= rdn + 1;
            end
            prev_op <= eng_op;
         end else ecnt <= ecnt + 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rd_valid) begin rq[nrd] <= rd_data; nrd <= nrd + 1; end
      if (wr_take) widx <= widx + 1;
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic after_done();
      @(negedge clk);
      chk(!busy && !eng_req && !done, "R12 idle after done", {busy, eng_req, done}, 0);
   endtask

   task automatic do_cmd(bit bg, bit en, bit rd, logic [6:0] a, int len);
      int  base = nlog;
      bit  ack  = (a < 7'h40);
      bit  stp  = !ack || (en && len == 0);
      @(negedge clk);
      cmd_begin = bg; cmd_end = en; cmd_read = rd; cmd_addr = a; cmd_len = LW'(len);
      cmd_valid = 1;
      @(negedge clk);
      cmd_valid = 0;
      wait_done();
      chk(lg_op[base] == (bg ? 3'd0 : 3'd1), "R2 opening condition", lg_op[base], bg ? 0 : 1);
      chk(lg_op[base+1] == 3'd3 && lg_dat[base+1] == {a, rd}, "R1 address byte",
          lg_dat[base+1], {a, rd});
      chk(nlog - base == 2 + stp, ack ? "R5 ops after address" : "R3 ops after address",
          nlog - base, 2 + stp);
      if (stp) chk(lg_op[base+2] == 3'd2, ack ? "R5 stop op" : "R3 stop op", lg_op[base+2], 2);
      chk(status == (ack ? 2'd1 : 2'd2), ack ? "R4 status" : "R3 status", status, ack ? 1 : 2);
      chk(done_count == 0, "R12 command count", done_count, 0);
      chk(wr_err == 1'b0, "R11 error cleared", wr_err, 0);
      m_stat = ack ? 1 : 2;
      m_rem  = ack ? len : 0;
      if (ack) m_end = en;
      m_err = 0;
      after_done();
   endtask

   task automatic do_chunk(bit wr, int cs);
      int base = nlog, rbase = nrd, wbase = widx;
      int g, k;
      bit stp;
      @(negedge clk);
      chunk_write = wr; chunk_len = LW'(cs); chunk_valid = 1;
      @(negedge clk);
      chunk_valid = 0;
      wait_done();
      if (m_stat == 1) begin
         g = (cs < m_rem) ? cs : m_rem;
         for (k = 0; k < g; k++) begin
            m_rem--;
            if (wr) begin
               chk(lg_op[base+k] == 3'd3 && lg_dat[base+k] == wbyte(ewi),
                   "R11 write byte", lg_dat[base+k], wbyte(ewi));
               if (wbyte(ewi) == 8'hEE) m_err = 1;
               ewi++;
            end else begin
               chk(lg_op[base+k] == 3'd4, "R8 read op", lg_op[base+k], 4);
               chk(lg_nk[base+k] == (m_rem == 0), "R8 nack on last", lg_nk[base+k], m_rem == 0);
               chk(rq[rbase+k] == 8'(8'hA0 + erdn), "R8 read byte", rq[rbase+k], 8'(8'hA0 + erdn));
               erdn++;
            end
         end
         stp = m_end && (m_rem == 0);
         chk(nlog - base == g + stp, "R9 op count with stop", nlog - base, g + stp);
         if (stp) chk(lg_op[base+g] == 3'd2, "R9 stop op", lg_op[base+g], 2);
         if (!wr) chk(nrd - rbase == g, "R8 bytes returned", nrd - rbase, g);
         chk(done_count == LW'(g), "R7 handled count", done_count, g);
      end else begin
         chk(nlog == base, "R10 no bus traffic", nlog - base, 0);
         chk(widx == wbase, "R10 no host byte taken", widx - wbase, 0);
         if (!wr) begin
            chk(nrd - rbase == cs, "R10 zero byte count", nrd - rbase, cs);
            for (k = 0; k < cs; k++) chk(rq[rbase+k] == 8'h00, "R10 zero byte", rq[rbase+k], 0);
         end
         chk(done_count == LW'(cs), "R10 handled count", done_count, cs);
      end
      chk(wr_err == m_err, "R11 error flag", wr_err, m_err);
      after_done();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(status == 2'd0, "R6 reset status", status, 0);
      chk(!busy && !eng_req && !done, "R12 reset idle", {busy, eng_req, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 2'd0 && !wr_err, "R6 status after reset", status, 0);
      // sweep over direction, flags and lengths with acknowledged addresses
      for (int rd = 0; rd < 2; rd++)
         for (int bg = 0; bg < 2; bg++)
            for (int en = 0; en < 2; en++)
               for (int len = 0; len < 5; len++) begin
                  do_cmd(bit'(bg), bit'(en), bit'(rd), 7'(7'h12 + len), len);
                  while (m_rem > 0) do_chunk(!bit'(rd), 2);
                  do_chunk(!bit'(rd), 1);
               end
      // refused address: no bus work for chunks
      do_cmd(1'b1, 1'b0, 1'b1, 7'h50, 3);
      do_chunk(1'b0, 3);
      do_chunk(1'b1, 2);
      do_cmd(1'b0, 1'b1, 1'b0, 7'h7F, 0);
      do_chunk(1'b0, 0);
      // oversize write chunk that meets a refused data byte, then error clear
      do_cmd(1'b1, 1'b1, 1'b0, 7'h21, 6);
      do_chunk(1'b1, 9);
      do_cmd(1'b1, 1'b1, 1'b0, 7'h22, 1);
      do_chunk(1'b1, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule